// File: doc/BRIEF.md
# Serial Interrupt Priority Chain

This block decides which of several interrupt sources is served when the processor acknowledges an interrupt. Each source owns one stage of a serial chain. A source raises its request input for one or more cycles, and the stage stores that as a pending flag. All pending flags together drive a single active-low request line to the processor. When the processor raises its acknowledge, the acknowledge enters the first stage of the chain. Each stage passes it on only when that stage has nothing pending. The first pending stage that receives the acknowledge stops it and becomes the winner. Position in the chain is the only source of priority: stage 0 ranks highest.

A small controller turns each acknowledge pulse into exactly one one-cycle grant phase, whatever the length of the pulse. The controller has three states. CTL_IDLE waits for the acknowledge, and the transition IDLE to GRANT fires when `ack_i` is sampled high. CTL_GRANT lets the acknowledge run down the chain for one cycle and captures the winner's vector address, and the transition GRANT to HOLD is unconditional. CTL_HOLD presents the captured vector until the acknowledge is released, and the transition HOLD to IDLE fires when `ack_i` is sampled low. Each stage has two states. STG_IDLE moves to STG_PEND when its request is sampled. STG_PEND moves back to STG_IDLE when the stage wins a grant and no new request arrives on that same edge. The winner's flag is cleared during the grant, so the next acknowledge serves the next pending source.

Top module: `irq_chain_resolver`

## Requirements
- R1: After reset `irq_n_o` is 1, `vec_valid_o` is 0, `vec_o` is 0 and no stage is pending.
- R2: `req_i[k]` sampled high at a rising edge makes stage k pending, and `irq_n_o` is 0 after that edge for as long as any stage is pending.
- R3: When `ack_i` is sampled high while the controller is idle, `vec_valid_o` is 1 after the second rising edge, and `vec_o` then holds the vector of the lowest-index pending stage. Index 0 has the highest priority.
- R4: A grant clears only the winning stage. Stages after the winner stay pending and are served by later acknowledges, in index order.
- R5: If no stage is pending during the grant phase, `vec_valid_o` stays 0 and `vec_o` stays 0. Whenever `vec_valid_o` is 0, `vec_o` is 0.
- R6: While `ack_i` stays high after a grant, `vec_o` and `vec_valid_o` hold their values and no further stage is cleared. Exactly one grant is made for each acknowledge pulse.
- R7: At the first rising edge that samples `ack_i` low in the hold phase, `vec_valid_o` and `vec_o` return to 0.
- R8: When the last pending stage is granted, `irq_n_o` returns to 1 after the grant edge.
- R9: If a winner's own request is sampled on the grant edge, that stage stays pending, because setting takes precedence over clearing.
- R10: The vector of stage k is `VEC_TABLE[k*VEC_W +: VEC_W]`. At most one stage wins in any grant phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Request input per source; bit k belongs to stage k |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| irq_n_o | output | 1 | Combined request, active low, 0 while any stage is pending |
| vec_o | output | VEC_W | Vector address of the granted stage, 0 when not valid |
| vec_valid_o | output | 1 | 1 while a granted vector is presented |

## Verification
A request sampled at an edge shows on `irq_n_o` right after that edge. A vector shows after the second edge that follows the acknowledge being sampled: one edge enters the grant phase and the next registers the result. The clear to zero follows one edge after `ack_i` is first sampled low in the hold phase. The bench drives inputs on falling edges and checks each result at the falling edge where that count of rising edges has passed. While the acknowledge is held, it checks again at every falling edge. A pending model kept in the bench supplies the expected winner and request line.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_GRANT = 2'd1,
        CTL_HOLD  = 2'd2
    } ctl_state_t;

    typedef enum logic {
        STG_IDLE = 1'b0,
        STG_PEND = 1'b1
    } stg_state_t;

endpackage

// File: rtl/irq_chain_stage.sv
module irq_chain_stage
    import irq_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic pi_i,
    output logic po_o,
    output logic win_o,
    output logic pend_o
);

    stg_state_t state_q;
    stg_state_t state_d;

    // Priority passes on only when this stage holds nothing; it stops here otherwise.
    assign pend_o = (state_q == STG_PEND);
    assign win_o  = pi_i & pend_o;
    assign po_o   = pi_i & ~pend_o;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STG_IDLE: begin
                if (set_i) state_d = STG_PEND;
            end
            STG_PEND: begin
                // A fresh request on the clearing edge keeps the flag.
                if (win_o && !set_i) state_d = STG_IDLE;
            end
            default: state_d = STG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STG_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/irq_chain_ctl.sv
module irq_chain_ctl
    import irq_chain_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_i,
    input  logic             hit_i,
    input  logic [VEC_W-1:0] win_vec_i,
    output logic             chain_ack_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_valid_o
);

    ctl_state_t state_q;
    ctl_state_t state_d;

    assign chain_ack_o = (state_q == CTL_GRANT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE:  if (ack_i)  state_d = CTL_GRANT;
            CTL_GRANT:             state_d = CTL_HOLD;
            CTL_HOLD:  if (!ack_i) state_d = CTL_IDLE;
            default:               state_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_o       <= '0;
            vec_valid_o <= 1'b0;
        end else begin
            unique case (state_q)
                CTL_GRANT: begin
                    vec_valid_o <= hit_i;
                    vec_o       <= hit_i ? win_vec_i : '0;
                end
                CTL_HOLD: begin
                    if (!ack_i) begin
                        vec_valid_o <= 1'b0;
                        vec_o       <= '0;
                    end
                end
                default: begin
                    vec_valid_o <= 1'b0;
                    vec_o       <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_chain_vecsel.sv
module irq_chain_vecsel #(
    parameter int                     N_SRC     = 4,
    parameter int                     VEC_W     = 8,
    parameter logic [N_SRC*VEC_W-1:0] VEC_TABLE = '0
) (
    input  logic [N_SRC-1:0] win_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             hit_o
);

    logic [VEC_W-1:0] masked [N_SRC];

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_mask
            localparam logic [VEC_W-1:0] STAGE_VEC = VEC_TABLE[g*VEC_W +: VEC_W];
            assign masked[g] = win_i[g] ? STAGE_VEC : '0;
        end
    endgenerate

    always_comb begin
        vec_o = '0;
        for (int k = 0; k < N_SRC; k++) vec_o = vec_o | masked[k];
    end

    assign hit_o = |win_i;

endmodule

// File: rtl/irq_chain_resolver.sv
module irq_chain_resolver #(
    parameter int                     N_SRC     = 4,
    parameter int                     VEC_W     = 8,
    parameter logic [N_SRC*VEC_W-1:0] VEC_TABLE = 32'h4030_2010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic             ack_i,
    output logic             irq_n_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_valid_o
);

    logic [N_SRC:0]   pri_link;
    logic [N_SRC-1:0] win_vec;
    logic [N_SRC-1:0] pend_vec;
    logic             chain_ack;
    logic             hit;
    logic [VEC_W-1:0] sel_vec;

    irq_chain_ctl #(.VEC_W(VEC_W)) ctl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (ack_i),
        .hit_i       (hit),
        .win_vec_i   (sel_vec),
        .chain_ack_o (chain_ack),
        .vec_o       (vec_o),
        .vec_valid_o (vec_valid_o)
    );

    assign pri_link[0] = chain_ack;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_stage
            irq_chain_stage stage_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (req_i[g]),
                .pi_i   (pri_link[g]),
                .po_o   (pri_link[g+1]),
                .win_o  (win_vec[g]),
                .pend_o (pend_vec[g])
            );
        end
    endgenerate

    irq_chain_vecsel #(
        .N_SRC     (N_SRC),
        .VEC_W     (VEC_W),
        .VEC_TABLE (VEC_TABLE)
    ) vecsel_i (
        .win_i (win_vec),
        .vec_o (sel_vec),
        .hit_o (hit)
    );

    assign irq_n_o = ~|pend_vec;

endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
    parameter int N_SRC = 4,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic             irq_n_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             vec_valid_o,
    input logic [N_SRC-1:0] win_vec
);

    // R10
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_vec));

    // R5
    grant_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid_o) |-> !$past(irq_n_o));

    // R5
    idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid_o |-> (vec_o == '0));

    // R3
    grant_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid_o) |-> $past(ack_i, 2));

    // R6
    held_vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && $past(vec_valid_o)) |-> $stable(vec_o));

    // R7
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !$past(ack_i)) |=> !vec_valid_o);

endmodule

bind irq_chain_resolver irq_chain_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .irq_n_o     (irq_n_o),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o),
    .win_vec     (win_vec)
);

// File: tb/irq_chain_resolver_tb.sv
`timescale 1ns/1ps
module irq_chain_resolver_tb_top;

    localparam int                     N     = 4;
    localparam int                     VW    = 8;
    localparam logic [N*VW-1:0]        TABLE = 32'h4030_2010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          ack = 1'b0;
    logic          irq_n;
    logic [VW-1:0] vec;
    logic          vec_valid;

    int n_checks = 0;
    int n_errors = 0;
    logic [N-1:0] model_pend = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_chain_resolver #(.N_SRC(N), .VEC_W(VW), .VEC_TABLE(TABLE)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .ack_i       (ack),
        .irq_n_o     (irq_n),
        .vec_o       (vec),
        .vec_valid_o (vec_valid)
    );

    function automatic int first_pending(input logic [N-1:0] p);
        for (int k = 0; k < N; k++) if (p[k]) return k;
        return -1;
    endfunction

    function automatic logic [VW-1:0] vec_of(input int k);
        return TABLE[k*VW +: VW];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic raise(input logic [N-1:0] mask);
        @(negedge clk) req = mask;
        @(negedge clk) req = '0;
        model_pend = model_pend | mask;
        check("R2 irq_n after request", 32'(irq_n), 32'(model_pend == '0));
    endtask

    // hold: acknowledge length in cycles; late_req: re-request winner on grant edge
    task automatic serve(input int hold, input bit late_req);
        int w;
        logic [VW-1:0] exp_vec;
        w = first_pending(model_pend);
        exp_vec = (w < 0) ? '0 : vec_of(w);
        @(negedge clk) ack = 1'b1;
        @(negedge clk);
        if (hold == 1) ack = 1'b0;
        if (late_req && w >= 0) req[w] = 1'b1;
        @(negedge clk) req = '0;
        if (w >= 0 && !late_req) model_pend[w] = 1'b0;
        check("R3 valid after grant", 32'(vec_valid), 32'(w >= 0));
        check("R3 R10 vector of winner", 32'(vec), 32'(exp_vec));
        check("R8 irq_n after grant", 32'(irq_n), 32'(model_pend == '0));
        for (int i = 2; i < hold; i++) begin
            @(negedge clk);
            check("R6 vector held", 32'(vec), 32'(exp_vec));
            check("R6 no second grant", 32'(irq_n), 32'(model_pend == '0));
        end
        ack = 1'b0;
        @(negedge clk);
        check("R7 valid cleared", 32'(vec_valid), 32'd0);
        check("R7 vector cleared", 32'(vec), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 irq_n in reset", 32'(irq_n), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq_n", 32'(irq_n), 32'd1);
        check("R1 valid", 32'(vec_valid), 32'd0);
        check("R1 vector", 32'(vec), 32'd0);

        // R5: acknowledge with nothing pending
        serve(2, 1'b0);

        // R4: all pending, served in index order
        raise(4'b1111);
        for (int k = 0; k < N; k++) serve(1 + k, 1'b0);
        check("R4 R8 all served", 32'(irq_n), 32'd1);

        // R4: lower entries wait behind a higher one
        raise(4'b1010);
        serve(3, 1'b0);
        raise(4'b0001);
        serve(1, 1'b0);
        serve(2, 1'b0);

        // R9: winner re-requests on grant edge
        raise(4'b0100);
        serve(1, 1'b1);
        check("R9 still pending", 32'(irq_n), 32'd0);
        serve(1, 1'b0);

        // R6: long hold does not drain further entries
        raise(4'b0011);
        serve(6, 1'b0);
        check("R6 one entry left", 32'(irq_n), 32'd0);
        serve(1, 1'b0);

        for (int it = 0; it < 40; it++) begin
            raise(N'($urandom_range(0, (1 << N) - 1)));
            serve(int'($urandom_range(1, 4)), 1'b0);
        end
        while (model_pend != '0) serve(1, 1'b0);
        check("R8 final irq_n", 32'(irq_n), 32'd1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule